// File: doc/BRIEF.md
# Multi-lane SPI shift engine

This block is the serial shift core that sits between the SPI clock logic and the data pins of an SPI master or slave. A byte is loaded with a one-cycle load strobe. The clock logic then sends one-cycle strobes for the leading and trailing edges of SCK. On those strobes the engine presents transmit bits on the lane outputs and captures receive bits from the lane inputs. Each shift event moves one, two or four bits. In double data rate (DDR) mode both SCK edges shift, so four lanes with DDR complete a byte within one SCK period.

The most significant bits leave first. In single-lane mode the transfer is full duplex: one lane sends while another receives, and the `slave_i` input picks which lane does which. In dual and quad mode the transfer is half duplex, and the direction bit selects whether the engine drives or listens. Each completed character is copied into a read buffer, with a one-cycle done pulse. The shifter can then start the next character while the previous one is being read. A load that arrives while a character is in flight is refused and reported on a collision pulse. Per-lane output enables drive the pad tristate controls.

Encodings: `lane_mode_i` is 00 for single, 01 for dual and 10 for quad. `tx_dir_i` = 1 means transmit. The configuration is captured at the load strobe and held for the whole character.

Top module: `mlspi_shift_engine`

## Requirements
- R1: After a synchronous reset, busy, done, collision and all output enables are 0, and the read buffer is 0.
- R2: A load while idle captures the byte and the configuration, and busy is 1 from the next cycle until the end of the character.
- R3: Each shift event moves 1, 2 or 4 bits, most significant first. In quad mode io3 carries bit 3 of each nibble and io0 carries bit 0. In dual mode io1 carries the higher bit of each pair.
- R4: Single-lane mode is full duplex and ignores the direction bit. With `slave_i`=0 the engine drives io0 and samples io1. With `slave_i`=1 it drives io1 and samples io0.
- R5: Dual and quad mode are half duplex. With `tx_dir_i`=0 no lane is enabled and the received bits go to the read buffer. With `tx_dir_i`=1 the lanes are driven and the read buffer keeps its previous value.
- R6: Without DDR and with CPHA=0, the first group is presented at load, the leading edge samples and the trailing edge advances. With CPHA=1, the first leading edge presents the first group, later leading edges advance and the trailing edge samples.
- R7: With DDR, every leading or trailing edge both samples and advances, and CPHA has no effect. A character takes 8/width edges, so quad DDR takes one leading and one trailing edge.
- R8: Done is a one-cycle pulse. It occurs in the cycle after the clock edge that samples the last group. The read buffer changes in that same cycle and holds until the next character completes.
- R9: A load while busy produces a one-cycle collision pulse in the next cycle. The byte is discarded and the running character continues unchanged.
- R10: Output enables mark only the lanes being driven, and only while busy. They are 0 when idle, in receive direction, and from the done cycle on.
- R11: Edge strobes while idle have no effect: busy and done stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load strobe for a new character |
| tx_byte_i | input | CHAR_W | Character to send |
| lane_mode_i | input | 2 | 00 single, 01 dual, 10 quad |
| ddr_i | input | 1 | Shift on both SCK edges |
| cpha_i | input | 1 | Clock phase select (SDR only) |
| tx_dir_i | input | 1 | 1 transmit, 0 receive (dual/quad) |
| slave_i | input | 1 | Swap single-lane send/receive lanes |
| lead_i | input | 1 | Leading SCK edge strobe |
| trail_i | input | 1 | Trailing SCK edge strobe |
| io_in_i | input | 4 | Lane inputs io0..io3 |
| io_out_o | output | 4 | Lane outputs io0..io3 |
| io_oe_o | output | 4 | Per-lane output enables |
| rx_data_o | output | CHAR_W | Read buffer |
| done_o | output | 1 | Character complete pulse |
| busy_o | output | 1 | Character in flight |
| wcol_o | output | 1 | Write collision pulse |

## Verification
If the bit counter is wrong, done arrives one or more edges early or late. The monitor then finds a missing or an extra character, or a byte whose low groups are shifted, in the done cycle itself. A wrong lane group or phase choice shows up on the lane outputs at the first advance edge of the character. A latched configuration that leaks between characters shows up as a wrong output-enable pattern, or as a read buffer that changed in transmit direction. A collision that is not refused corrupts the very next lane group.

// File: rtl/mlspi_pkg.sv
package mlspi_pkg;

    localparam int IO_LANES = 4;

    typedef enum logic [1:0] {
        LANES_X1 = 2'b00,
        LANES_X2 = 2'b01,
        LANES_X4 = 2'b10
    } lane_mode_e;

    typedef struct packed {
        lane_mode_e mode;
        logic       ddr;
        logic       cpha;
        logic       tx_dir;
        logic       slave;
    } xfer_cfg_t;

    typedef struct packed {
        logic sample;
        logic advance;
    } shift_ev_t;

    function automatic int unsigned group_bits(lane_mode_e m);
        case (m)
            LANES_X1: return 1;
            LANES_X2: return 2;
            default:  return 4;
        endcase
    endfunction

    function automatic logic [IO_LANES-1:0] drive_mask(xfer_cfg_t c);
        case (c.mode)
            LANES_X1: return c.slave ? 4'b0010 : 4'b0001;
            LANES_X2: return c.tx_dir ? 4'b0011 : 4'b0000;
            default:  return c.tx_dir ? 4'b1111 : 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/mlspi_edge_ctl.sv
module mlspi_edge_ctl
    import mlspi_pkg::*;
(
    input  logic      active_i,
    input  logic      started_i,
    input  xfer_cfg_t cfg_i,
    input  logic      lead_i,
    input  logic      trail_i,
    output shift_ev_t ev_o
);

    always_comb begin
        ev_o = '0;
        if (active_i) begin
            if (cfg_i.ddr) begin
                ev_o.sample  = lead_i | trail_i;
                ev_o.advance = lead_i | trail_i;
            end else if (!cfg_i.cpha) begin
                ev_o.sample  = lead_i;
                ev_o.advance = trail_i;
            end else begin
                // first leading edge only presents the first group
                ev_o.sample  = trail_i;
                ev_o.advance = lead_i & started_i;
            end
        end
    end

endmodule

// File: rtl/mlspi_shifter.sv
module mlspi_shifter
    import mlspi_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  logic [CHAR_W-1:0]   tx_byte_i,
    input  xfer_cfg_t           cfg_i,
    input  shift_ev_t           ev_i,
    input  logic [IO_LANES-1:0] rx_grp_i,
    output logic [IO_LANES-1:0] tx_grp_o,
    output logic [CHAR_W-1:0]   rx_next_o,
    output logic                last_o
);

    localparam int CNT_W = $clog2(CHAR_W + 1);

    logic [CHAR_W-1:0] tx_sh, rx_sh, tx_adv;
    logic [CNT_W-1:0]  cnt, step;

    always_comb begin
        case (cfg_i.mode)
            LANES_X1: begin
                tx_grp_o  = {3'b000, tx_sh[CHAR_W-1]};
                tx_adv    = {tx_sh[CHAR_W-2:0], 1'b0};
                rx_next_o = {rx_sh[CHAR_W-2:0], rx_grp_i[0]};
            end
            LANES_X2: begin
                tx_grp_o  = {2'b00, tx_sh[CHAR_W-1 -: 2]};
                tx_adv    = {tx_sh[CHAR_W-3:0], 2'b00};
                rx_next_o = {rx_sh[CHAR_W-3:0], rx_grp_i[1:0]};
            end
            default: begin
                tx_grp_o  = tx_sh[CHAR_W-1 -: 4];
                tx_adv    = {tx_sh[CHAR_W-5:0], 4'b0000};
                rx_next_o = {rx_sh[CHAR_W-5:0], rx_grp_i[3:0]};
            end
        endcase
        step   = CNT_W'(group_bits(cfg_i.mode));
        last_o = ev_i.sample && ((cnt + step) == CNT_W'(CHAR_W));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh <= '0;
            rx_sh <= '0;
            cnt   <= '0;
        end else if (load_i) begin
            tx_sh <= tx_byte_i;
            rx_sh <= '0;
            cnt   <= '0;
        end else begin
            if (ev_i.advance) tx_sh <= tx_adv;
            if (ev_i.sample) begin
                rx_sh <= rx_next_o;
                cnt   <= cnt + step;
            end
        end
    end

endmodule

// File: rtl/mlspi_lane_map.sv
module mlspi_lane_map
    import mlspi_pkg::*;
(
    input  xfer_cfg_t           cfg_i,
    input  logic                active_i,
    input  logic [IO_LANES-1:0] tx_grp_i,
    input  logic [IO_LANES-1:0] io_in_i,
    output logic [IO_LANES-1:0] io_out_o,
    output logic [IO_LANES-1:0] io_oe_o,
    output logic [IO_LANES-1:0] rx_grp_o
);

    always_comb begin
        case (cfg_i.mode)
            LANES_X1: begin
                io_out_o = cfg_i.slave ? {2'b00, tx_grp_i[0], 1'b0}
                                       : {3'b000, tx_grp_i[0]};
                rx_grp_o = {3'b000, cfg_i.slave ? io_in_i[0] : io_in_i[1]};
            end
            LANES_X2: begin
                io_out_o = {2'b00, tx_grp_i[1:0]};
                rx_grp_o = {2'b00, io_in_i[1:0]};
            end
            default: begin
                io_out_o = tx_grp_i;
                rx_grp_o = io_in_i;
            end
        endcase
        io_oe_o = active_i ? drive_mask(cfg_i) : '0;
    end

endmodule

// File: rtl/mlspi_shift_engine.sv
module mlspi_shift_engine
    import mlspi_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [CHAR_W-1:0] tx_byte_i,
    input  logic [1:0]        lane_mode_i,
    input  logic              ddr_i,
    input  logic              cpha_i,
    input  logic              tx_dir_i,
    input  logic              slave_i,
    input  logic              lead_i,
    input  logic              trail_i,
    input  logic [3:0]        io_in_i,
    output logic [3:0]        io_out_o,
    output logic [3:0]        io_oe_o,
    output logic [CHAR_W-1:0] rx_data_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              wcol_o
);

    xfer_cfg_t           cfg_q, cfg_in;
    shift_ev_t           ev;
    logic                busy_q, started_q, done_q, wcol_q, load_ok, last;
    logic [CHAR_W-1:0]   rbuf_q, rx_next;
    logic [IO_LANES-1:0] tx_grp, rx_grp;

    always_comb begin
        cfg_in.mode   = lane_mode_e'(lane_mode_i);
        cfg_in.ddr    = ddr_i;
        cfg_in.cpha   = cpha_i;
        cfg_in.tx_dir = tx_dir_i;
        cfg_in.slave  = slave_i;
        load_ok       = load_i & ~busy_q;
    end

    mlspi_edge_ctl u_edge (
        .active_i  (busy_q),
        .started_i (started_q),
        .cfg_i     (cfg_q),
        .lead_i    (lead_i),
        .trail_i   (trail_i),
        .ev_o      (ev)
    );

    mlspi_shifter #(.CHAR_W(CHAR_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_ok),
        .tx_byte_i (tx_byte_i),
        .cfg_i     (cfg_q),
        .ev_i      (ev),
        .rx_grp_i  (rx_grp),
        .tx_grp_o  (tx_grp),
        .rx_next_o (rx_next),
        .last_o    (last)
    );

    mlspi_lane_map u_map (
        .cfg_i     (cfg_q),
        .active_i  (busy_q),
        .tx_grp_i  (tx_grp),
        .io_in_i   (io_in_i),
        .io_out_o  (io_out_o),
        .io_oe_o   (io_oe_o),
        .rx_grp_o  (rx_grp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            busy_q    <= 1'b0;
            started_q <= 1'b0;
            done_q    <= 1'b0;
            wcol_q    <= 1'b0;
            rbuf_q    <= '0;
        end else begin
            done_q <= last;
            wcol_q <= load_i & busy_q;
            if (load_ok) begin
                cfg_q     <= cfg_in;
                busy_q    <= 1'b1;
                started_q <= 1'b0;
            end else begin
                if (last) busy_q <= 1'b0;
                if (busy_q && lead_i) started_q <= 1'b1;
            end
            if (last && (cfg_q.mode == LANES_X1 || !cfg_q.tx_dir))
                rbuf_q <= rx_next;
        end
    end

    assign rx_data_o = rbuf_q;
    assign done_o    = done_q;
    assign busy_o    = busy_q;
    assign wcol_o    = wcol_q;

endmodule

// File: rtl/mlspi_shift_engine_chk.sv
module mlspi_shift_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       load_i,
    input logic [3:0] io_oe_o,
    input logic       done_o,
    input logic       busy_o,
    input logic       wcol_o
);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    // R9
    wcol_cause_chk: assert property (@(posedge clk) disable iff (rst)
        wcol_o |-> $past(load_i && busy_o));

    // R2
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && !busy_o) |=> busy_o);

    // R10
    idle_oe_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (io_oe_o == 4'b0000));

    // R10
    oe_shape_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (io_oe_o == 4'b0000 || io_oe_o == 4'b0001 ||
                    io_oe_o == 4'b0010 || io_oe_o == 4'b0011 ||
                    io_oe_o == 4'b1111));

endmodule

bind mlspi_shift_engine mlspi_shift_engine_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .io_oe_o (io_oe_o),
    .done_o  (done_o),
    .busy_o  (busy_o),
    .wcol_o  (wcol_o)
);

// File: tb/mlspi_shift_engine_tb.sv
module mlspi_shift_engine_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_i = 1'b0;
    logic [7:0] tx_byte_i = '0;
    logic [1:0] lane_mode_i = '0;
    logic       ddr_i = 1'b0, cpha_i = 1'b0, tx_dir_i = 1'b0, slave_i = 1'b0;
    logic       lead_i = 1'b0, trail_i = 1'b0;
    logic [3:0] io_in_i = '0;
    logic [3:0] io_out_o, io_oe_o;
    logic [7:0] rx_data_o;
    logic       done_o, busy_o, wcol_o;

    int n_chk = 0;
    int n_fail = 0;
    int n_done = 0;
    logic [7:0] exp_q[$];
    logic [7:0] last_rbuf = 8'h00;
    bit finished = 0;

    always #5 clk = ~clk;

    mlspi_shift_engine #(.CHAR_W(8)) u_dut (.*);

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done_o) begin
            n_done++;
            if (exp_q.size() == 0) begin
                chk(0, "R8 unexpected done", 1, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rx_data_o == e, "R8 read buffer", rx_data_o, e);
            end
            chk(io_oe_o == 4'b0000, "R10 oe at done", io_oe_o, 0);
        end
    end

    task automatic xfer(input logic [1:0] mode, input bit ddr, input bit cpha,
                        input bit dir, input bit slv, input logic [7:0] txb,
                        input logic [7:0] rxb, input bit collide,
                        input string tag);
        int w, n, d0;
        logic [3:0] mask, eoe;
        bit drives;
        w = (mode == 2'b00) ? 1 : (mode == 2'b01) ? 2 : 4;
        n = 8 / w;
        mask = 4'((1 << w) - 1);
        drives = (mode == 2'b00) || dir;
        if (mode == 2'b00) eoe = slv ? 4'b0010 : 4'b0001;
        else if (!dir)     eoe = 4'b0000;
        else               eoe = (mode == 2'b01) ? 4'b0011 : 4'b1111;
        if (mode == 2'b00 || !dir) begin
            exp_q.push_back(rxb);
            last_rbuf = rxb;
        end else begin
            exp_q.push_back(last_rbuf);
        end
        d0 = n_done;
        lane_mode_i = mode; ddr_i = ddr; cpha_i = cpha;
        tx_dir_i = dir; slave_i = slv; tx_byte_i = txb; load_i = 1'b1;
        step();
        load_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after load", busy_o, 1);
        for (int k = 0; k < n; k++) begin
            logic [3:0] tg, rg, act;
            tg = 4'(txb >> (8 - (k + 1) * w)) & mask;
            rg = 4'(rxb >> (8 - (k + 1) * w)) & mask;
            if (collide && k == 1) begin
                load_i = 1'b1; tx_byte_i = ~txb;
                step();
                load_i = 1'b0; tx_byte_i = txb;
                chk(wcol_o == 1'b1, "R9 collision pulse", wcol_o, 1);
                chk(busy_o == 1'b1, "R9 still busy", busy_o, 1);
            end
            if (!ddr && cpha) begin
                lead_i = 1'b1; step(); lead_i = 1'b0;
            end
            // lane output check
            if (mode == 2'b00) act = {3'b000, io_out_o[slv ? 1 : 0]};
            else act = io_out_o & mask;
            if (drives) chk(act == tg, tag, act, tg);
            chk(io_oe_o == eoe, "R10 oe pattern", io_oe_o, eoe);
            // receive lanes
            if (mode == 2'b00) io_in_i = slv ? {3'b110, rg[0]} : {2'b10, rg[0], ~rg[0]};
            else if (mode == 2'b01) io_in_i = {2'b11, rg[1:0]};
            else io_in_i = rg;
            if (ddr) begin
                if (k % 2 == 0) lead_i = 1'b1; else trail_i = 1'b1;
                step(); lead_i = 1'b0; trail_i = 1'b0;
            end else if (!cpha) begin
                lead_i = 1'b1; step(); lead_i = 1'b0;
                trail_i = 1'b1; step(); trail_i = 1'b0;
            end else begin
                trail_i = 1'b1; step(); trail_i = 1'b0;
            end
        end
        step();
        chk(n_done == d0 + 1, {tag, " one done per char"}, n_done, d0 + 1);
        chk(busy_o == 1'b0, "R8 idle after char", busy_o, 0);
        chk(done_o == 1'b0, "R8 done single cycle", done_o, 0);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk(busy_o == 0, "R1 busy", busy_o, 0);
        chk(done_o == 0, "R1 done", done_o, 0);
        chk(wcol_o == 0, "R1 wcol", wcol_o, 0);
        chk(io_oe_o == 0, "R1 oe", io_oe_o, 0);
        chk(rx_data_o == 0, "R1 rbuf", rx_data_o, 0);
        // R11 idle strobes ignored
        lead_i = 1'b1; step(); lead_i = 1'b0;
        trail_i = 1'b1; step(); trail_i = 1'b0;
        step();
        chk(busy_o == 0, "R11 busy idle", busy_o, 0);
        chk(done_o == 0, "R11 done idle", done_o, 0);
        chk(io_oe_o == 0, "R11 oe idle", io_oe_o, 0);

        xfer(2'b00, 0, 0, 1, 0, 8'hA5, 8'h3C, 0, "R4 single master cpha0");
        xfer(2'b00, 0, 1, 1, 0, 8'h96, 8'hE1, 0, "R6 single master cpha1");
        xfer(2'b00, 0, 0, 0, 1, 8'h5A, 8'h81, 0, "R4 single slave");
        xfer(2'b01, 0, 0, 1, 0, 8'hB4, 8'h00, 0, "R3 dual tx");
        xfer(2'b01, 0, 1, 0, 0, 8'h00, 8'h6D, 0, "R5 dual rx cpha1");
        xfer(2'b10, 0, 0, 1, 0, 8'hC3, 8'h00, 0, "R3 quad tx");
        xfer(2'b10, 0, 1, 0, 0, 8'h00, 8'h2F, 0, "R5 quad rx");
        xfer(2'b10, 1, 0, 0, 0, 8'h00, 8'hA7, 0, "R7 quad ddr rx");
        xfer(2'b10, 1, 1, 1, 0, 8'h1E, 8'h00, 0, "R7 quad ddr tx");
        xfer(2'b01, 1, 0, 0, 0, 8'h00, 8'h93, 0, "R7 dual ddr rx");
        xfer(2'b00, 1, 0, 1, 1, 8'h55, 8'hAA, 0, "R7 single ddr");
        xfer(2'b00, 0, 0, 1, 0, 8'hC9, 8'h72, 1, "R9 collision ignored");
        xfer(2'b10, 0, 0, 1, 0, 8'h6B, 8'h00, 1, "R9 quad collision");

        chk(exp_q.size() == 0, "R8 all chars seen", exp_q.size(), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule